// File: doc/BRIEF.md
# Per-Context Interrupt Routing Controller

The block collects 32 level-sensitive peripheral interrupt lines and steers each of them onto one of 15 interrupt outputs. There are two independent sets of outputs, one for each of two processor contexts. Every context owns its own register bank: an enable mask, a read-only status view of the input levels, and four routing registers. The routing registers hold a 4-bit selector for every input. Software can point an input at an output in one context and leave it unconnected in the other.

Each input is passed through a two-flop synchronizer. The synchronized level is what the status register shows. An input is pending in a context when it is high and its mask bit is set. An output is the registered OR of every pending input whose selector names that output. Nothing is latched, so an output falls as soon as the last active input routed to it goes low. A word-wide register port with combinational read data gives access to both banks.

Top module: `irq_route_ctrl`

## Requirements
- R1: The block has 32 inputs and two contexts of 15 outputs each. Output o of context c is irq_o bit c*15+o.
- R2: Offset 0x04 of a bank reads the synchronized input levels, with input n at bit n. Writes to this offset change no register.
- R3: Offset 0x00 of a bank is the read/write enable mask, with input n at bit n.
- R4: The 4-bit selector for input n sits at bits [4*(n mod 8)+3 : 4*(n mod 8)] of the routing register at offset 0x14 - 4*(n div 8). So inputs 24..31 are at 0x08, 16..23 at 0x0C, 8..15 at 0x10 and 0..7 at 0x14. These registers are read/write.
- R5: Output o of a context is high when at least one input is both high and unmasked in that context and has a selector equal to o+1 there.
- R6: A selector value of 0 connects the input to no output.
- R7: A change on an input reaches the outputs on the third rising clock edge after it is applied. A register write takes effect on the outputs at the edge after the write edge.
- R8: Address bit 5 selects the context bank (0x00..0x1F for context 0, 0x20..0x3F for context 1). A write to one bank leaves the other bank unchanged.
- R9: After reset all masks and selectors are zero and all outputs are low.
- R10: Offsets 0x18 and 0x1C of a bank, and every address with bits [1:0] not equal to zero, read as zero. Writes to them are ignored.
- R11: An output stays high for as long as a pending input routed to it stays high. It returns low once that input drops and no other pending input routed to it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 32 | Peripheral interrupt levels |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Byte address: bit 5 selects the context, bits 4:2 select the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 30 | Routed outputs, 15 per context |

## Verification
The hardest case to reach from the ports has two parts. Each input's nibble must land on the correct output. At the same time, every other input must stay active but masked or unrouted, so that a misplaced selector or a wrong routing-register index becomes visible. The bench sweeps every input in both contexts with all other inputs held high, and gives each input a different output selector per context. It then checks that exactly one output bit rises, and that it falls again when only that input is dropped. Separate passes check the exact edge on which an output changes, writes to the status register and the unmapped words, and a bank that stays silent while the other bank routes the same input.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int unsigned IRQ_N_IN   = 32;
  localparam int unsigned IRQ_N_OUT  = 15;
  localparam int unsigned IRQ_N_CTX  = 2;
  localparam int unsigned IRQ_FLD_W  = 4;
  localparam int unsigned IRQ_DATA_W = 32;
  localparam int unsigned IRQ_WORD_W = 3;
  // word indices inside one bank
  localparam int unsigned W_MASK   = 0;
  localparam int unsigned W_STAT   = 1;
  localparam int unsigned W_RR0    = 2;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/irq_route_matrix.sv
module irq_route_matrix #(
  parameter int unsigned N_IN  = 32,
  parameter int unsigned N_OUT = 15,
  parameter int unsigned FLD_W = 4
) (
  input  logic [N_IN-1:0]       pend_i,
  input  logic [N_IN*FLD_W-1:0] fld_i,
  output logic [N_OUT-1:0]      hit_o
);
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_IN-1:0] sel;
    for (genvar n = 0; n < N_IN; n++) begin : g_in
      // selector o+1 drives output o; 0 never matches
      assign sel[n] = (fld_i[n*FLD_W +: FLD_W] == FLD_W'(o + 1));
    end
    assign hit_o[o] = |(sel & pend_i);
  end
endmodule

// File: rtl/irq_ctx_bank.sv
module irq_ctx_bank #(
  parameter int unsigned N_IN   = 32,
  parameter int unsigned N_OUT  = 15,
  parameter int unsigned FLD_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned WORD_W = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic                  hit_i,
  input  logic [WORD_W-1:0]     word_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [N_IN-1:0]       stat_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [N_OUT-1:0]      irq_o,
  output logic [N_IN-1:0]       mask_o,
  output logic [N_IN*FLD_W-1:0] fld_o
);
  import irq_route_pkg::*;

  localparam int unsigned FPR  = DATA_W / FLD_W;  // fields per register
  localparam int unsigned N_RR = N_IN / FPR;      // routing registers

  logic [N_IN-1:0]       mask_q;
  logic [N_IN*FLD_W-1:0] fld_q;
  logic [N_OUT-1:0]      out_d, out_q;
  logic [N_IN-1:0]       pend;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      fld_q  <= '0;
    end else if (wr_i && hit_i) begin
      if (word_i == WORD_W'(W_MASK)) mask_q <= wdata_i[N_IN-1:0];
      for (int r = 0; r < N_RR; r++) begin
        if (word_i == WORD_W'(W_RR0 + r)) begin
          // reversed order: first routing word holds the top inputs
          for (int j = 0; j < FPR; j++)
            fld_q[((N_RR-1-r)*FPR + j)*FLD_W +: FLD_W] <= wdata_i[j*FLD_W +: FLD_W];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      if (word_i == WORD_W'(W_MASK)) rdata_o[N_IN-1:0] = mask_q;
      if (word_i == WORD_W'(W_STAT)) rdata_o[N_IN-1:0] = stat_i;
      for (int r = 0; r < N_RR; r++) begin
        if (word_i == WORD_W'(W_RR0 + r)) begin
          for (int j = 0; j < FPR; j++)
            rdata_o[j*FLD_W +: FLD_W] = fld_q[((N_RR-1-r)*FPR + j)*FLD_W +: FLD_W];
        end
      end
    end
  end

  assign pend = mask_q & stat_i;

  irq_route_matrix #(
    .N_IN (N_IN),
    .N_OUT(N_OUT),
    .FLD_W(FLD_W)
  ) u_matrix (
    .pend_i(pend),
    .fld_i (fld_q),
    .hit_o (out_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_q <= '0;
    else         out_q <= out_d;
  end

  assign irq_o  = out_q;
  assign mask_o = mask_q;
  assign fld_o  = fld_q;
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int unsigned N_IN   = IRQ_N_IN,
  parameter int unsigned N_OUT  = IRQ_N_OUT,
  parameter int unsigned N_CTX  = IRQ_N_CTX,
  parameter int unsigned FLD_W  = IRQ_FLD_W,
  parameter int unsigned DATA_W = IRQ_DATA_W,
  localparam int unsigned WORD_W = IRQ_WORD_W,
  localparam int unsigned CTX_W  = (N_CTX > 1) ? $clog2(N_CTX) : 1,
  localparam int unsigned ADDR_W = WORD_W + 2 + CTX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IN-1:0]        irq_i,
  input  logic                   wr_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [DATA_W-1:0]      rdata_o,
  output logic [N_CTX*N_OUT-1:0] irq_o
);
  logic [N_IN-1:0]             stat_q;
  logic [CTX_W-1:0]            ctx_sel;
  logic [WORD_W-1:0]           word_sel;
  logic                        aligned;
  logic [DATA_W-1:0]           bank_rd [N_CTX];
  logic [N_CTX*N_IN-1:0]       mask_flat;
  logic [N_CTX*N_IN*FLD_W-1:0] route_flat;

  assign ctx_sel  = addr_i[ADDR_W-1 -: CTX_W];
  assign word_sel = addr_i[WORD_W+1:2];
  assign aligned  = (addr_i[1:0] == 2'b00);

  irq_sync #(.W(N_IN)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (stat_q)
  );

  for (genvar c = 0; c < N_CTX; c++) begin : g_ctx
    logic hit;
    assign hit = aligned && (ctx_sel == CTX_W'(c));

    irq_ctx_bank #(
      .N_IN  (N_IN),
      .N_OUT (N_OUT),
      .FLD_W (FLD_W),
      .DATA_W(DATA_W),
      .WORD_W(WORD_W)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_en_i),
      .hit_i  (hit),
      .word_i (word_sel),
      .wdata_i(wdata_i),
      .stat_i (stat_q),
      .rdata_o(bank_rd[c]),
      .irq_o  (irq_o[c*N_OUT +: N_OUT]),
      .mask_o (mask_flat[c*N_IN +: N_IN]),
      .fld_o  (route_flat[c*N_IN*FLD_W +: N_IN*FLD_W])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < N_CTX; c++)
      rdata_o = rdata_o | bank_rd[c];
  end
endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
  parameter int unsigned N_IN   = 32,
  parameter int unsigned N_OUT  = 15,
  parameter int unsigned N_CTX  = 2,
  parameter int unsigned FLD_W  = 4,
  parameter int unsigned ADDR_W = 6
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic [N_IN-1:0]              irq_i,
  input logic                         wr_en_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic [N_CTX*N_OUT-1:0]       irq_o,
  input logic [N_IN-1:0]              stat_q,
  input logic [N_CTX*N_IN-1:0]        mask_flat,
  input logic [N_CTX*N_IN*FLD_W-1:0]  route_flat
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  // R7: status is the input delayed by two edges
  a_r7_sync_depth: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (stat_q == $past(irq_i, 2)));

  // R2: writes to the status word touch no register
  a_r2_status_readonly: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[4:2] == 3'd1) |=> ($stable(mask_flat) && $stable(route_flat)));

  // R10: unmapped words and misaligned addresses ignore writes
  a_r10_hole_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (addr_i[4:3] == 2'b11 || addr_i[1:0] != 2'b00))
      |=> ($stable(mask_flat) && $stable(route_flat)));

  for (genvar c = 0; c < N_CTX; c++) begin : g_c
    // R5: a fully masked context keeps its outputs low
    a_r5_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_flat[c*N_IN +: N_IN] == '0) |=> (irq_o[c*N_OUT +: N_OUT] == '0));

    // R6: all-zero selectors leave a context silent
    a_r6_unrouted_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (route_flat[c*N_IN*FLD_W +: N_IN*FLD_W] == '0) |=> (irq_o[c*N_OUT +: N_OUT] == '0));

    // R8: writes to another bank leave this one unchanged
    a_r8_bank_isolation: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i[ADDR_W-1] != 1'(c))
        |=> ($stable(mask_flat[c*N_IN +: N_IN]) &&
             $stable(route_flat[c*N_IN*FLD_W +: N_IN*FLD_W])));
  end

  // R9: outputs low while reset is held
  always @(negedge clk_i) begin
    if (!rst_ni) a_r9_reset_quiet: assert (irq_o == '0);
  end
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
  .N_IN  (N_IN),
  .N_OUT (N_OUT),
  .N_CTX (N_CTX),
  .FLD_W (FLD_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .irq_i     (irq_i),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .irq_o     (irq_o),
  .stat_q    (stat_q),
  .mask_flat (mask_flat),
  .route_flat(route_flat)
);

// File: tb/irq_route_ctrl_test.sv
module irq_route_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] irq = '0;
  logic        wr_en = 0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [29:0] irq_out;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [31:0] m_mask [2];
  logic [3:0]  m_fld  [2][32];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_route_ctrl uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .irq_i  (irq),
    .wr_en_i(wr_en),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic bus_rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic settle(input int k);
    repeat (k) @(negedge clk);
  endtask

  function automatic logic [31:0] reg_val(input int c, input int r);
    logic [31:0] v = '0;
    for (int j = 0; j < 8; j++) v[4*j +: 4] = m_fld[c][(3-r)*8 + j];
    return v;
  endfunction

  function automatic logic [5:0] rr_addr(input int c, input int r);
    return 6'(c*32 + 8 + 4*r);
  endfunction

  task automatic set_fld(input int c, input int n, input logic [3:0] k);
    int r;
    m_fld[c][n] = k;
    r = 3 - n/8;
    bus_wr(rr_addr(c, r), reg_val(c, r));
  endtask

  task automatic set_mask(input int c, input logic [31:0] m);
    m_mask[c] = m;
    bus_wr(6'(c*32), m);
  endtask

  function automatic logic [31:0] exp_out(input logic [31:0] lv);
    logic [31:0] e = '0;
    for (int c = 0; c < 2; c++)
      for (int n = 0; n < 32; n++)
        if (lv[n] && m_mask[c][n] && m_fld[c][n] != 0)
          e[c*15 + int'(m_fld[c][n]) - 1] = 1'b1;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < 2; c++) begin
      m_mask[c] = '0;
      for (int n = 0; n < 32; n++) m_fld[c][n] = '0;
    end
    repeat (3) @(negedge clk);
    chk("R9 outputs during reset", {2'b0, irq_out}, 32'h0);
    rst_n = 1;
    settle(2);

    // R9: all registers clear after reset
    for (int c = 0; c < 2; c++)
      for (int w = 0; w < 8; w++) begin
        bus_rd(6'(c*32 + 4*w), d);
        chk("R9 register reset value", d, 32'h0);
      end
    chk("R9 outputs after reset", {2'b0, irq_out}, 32'h0);

    // R4/R3: routing and mask registers read back
    for (int c = 0; c < 2; c++) begin
      for (int r = 0; r < 4; r++) begin
        bus_wr(rr_addr(c, r), 32'h1357_9BDF ^ 32'(r*32'h1111_0000 + c*7));
        bus_rd(rr_addr(c, r), d);
        chk("R4 routing readback", d, 32'h1357_9BDF ^ 32'(r*32'h1111_0000 + c*7));
        bus_wr(rr_addr(c, r), 32'h0);
      end
      bus_wr(6'(c*32), 32'hA5C3_0F81 + 32'(c));
      bus_rd(6'(c*32), d);
      chk("R3 mask readback", d, 32'hA5C3_0F81 + 32'(c));
      bus_wr(6'(c*32), 32'h0);
    end

    // R10: holes and misaligned addresses
    for (int c = 0; c < 2; c++) begin
      bus_wr(6'(c*32 + 8'h18), 32'hFFFF_FFFF);
      bus_wr(6'(c*32 + 8'h1C), 32'hFFFF_FFFF);
      bus_wr(6'(c*32 + 1), 32'hFFFF_FFFF);
      bus_rd(6'(c*32 + 8'h18), d); chk("R10 hole 0x18 reads zero", d, 32'h0);
      bus_rd(6'(c*32 + 8'h1C), d); chk("R10 hole 0x1C reads zero", d, 32'h0);
      bus_rd(6'(c*32 + 1), d);     chk("R10 misaligned read zero", d, 32'h0);
      bus_rd(6'(c*32), d);         chk("R10 mask untouched", d, 32'h0);
      for (int r = 0; r < 4; r++) begin
        bus_rd(rr_addr(c, r), d);  chk("R10 routing untouched", d, 32'h0);
      end
    end

    // R1/R4/R5/R11: per-input sweep, all other inputs active but masked/unrouted
    for (int c = 0; c < 2; c++)
      for (int n = 0; n < 32; n++) begin
        int k;
        logic [31:0] e;
        k = ((n + 7*c) % 15) + 1;
        set_fld(c, n, 4'(k));
        set_mask(c, 32'h1 << n);
        irq = 32'hFFFF_FFFF;
        settle(4);
        e = 32'h1 << (c*15 + k - 1);
        chk($sformatf("R4 R5 input %0d ctx %0d selector %0d", n, c, k), {2'b0, irq_out}, e);
        irq = ~(32'h1 << n);
        settle(4);
        chk($sformatf("R11 input %0d ctx %0d drop", n, c), {2'b0, irq_out}, 32'h0);
        irq = 32'hFFFF_FFFF;
        settle(4);
        chk("R11 held while active", {2'b0, irq_out}, e);
        set_fld(c, n, 4'h0);
        settle(2);
        chk("R6 selector zero disconnects", {2'b0, irq_out}, 32'h0);
        set_mask(c, 32'h0);
        irq = '0;
      end

    // R7: input latency, exactly three edges
    set_fld(0, 5, 4'd3);
    set_mask(0, 32'h20);
    settle(1);
    irq = 32'h20;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk("R7 not yet after two edges", {2'b0, irq_out}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R7 visible after three edges", {2'b0, irq_out}, 32'h4);
    // R7: write latency, one edge after the write edge
    @(negedge clk);
    addr = 6'h00; wdata = 32'h0; wr_en = 1;
    @(posedge clk); #1 wr_en = 0;
    @(negedge clk);
    chk("R7 old mask until next edge", {2'b0, irq_out}, 32'h4);
    @(posedge clk); @(negedge clk);
    chk("R7 mask write applied", {2'b0, irq_out}, 32'h0);
    m_mask[0] = 32'h0;

    // R2: status view and read-only behaviour
    irq = 32'hC0DE_1234;
    settle(3);
    bus_rd(6'h04, d); chk("R2 status ctx0", d, 32'hC0DE_1234);
    bus_rd(6'h24, d); chk("R2 status ctx1", d, 32'hC0DE_1234);
    bus_wr(6'h04, 32'h0);
    bus_wr(6'h24, 32'hFFFF_FFFF);
    bus_rd(6'h04, d); chk("R2 status write ignored", d, 32'hC0DE_1234);
    bus_rd(6'h00, d); chk("R2 mask unaffected by status write", d, 32'h0);
    bus_rd(rr_addr(0, 3), d); chk("R2 routing unaffected by status write", d, reg_val(0, 3));

    // R8: same input routed in ctx0, disconnected in ctx1
    set_mask(1, 32'h20);
    irq = 32'h20;
    settle(4);
    chk("R8 ctx1 masked but unrouted", {2'b0, irq_out}, 32'h0);
    set_mask(0, 32'h20);
    settle(3);
    chk("R8 only ctx0 output", {2'b0, irq_out}, 32'h4);
    bus_rd(rr_addr(1, 3), d); chk("R8 ctx1 routing untouched", d, 32'h0);

    // R5/R1: full-route patterns in both contexts
    for (int c = 0; c < 2; c++)
      for (int n = 0; n < 32; n++) m_fld[c][n] = 4'((n*(c+2) + c) % 16);
    for (int c = 0; c < 2; c++)
      for (int r = 0; r < 4; r++) bus_wr(rr_addr(c, r), reg_val(c, r));
    for (int p = 0; p < 12; p++) begin
      logic [31:0] lv;
      lv = 32'h9E37_79B9 * 32'(p + 1) ^ (32'h1 << p);
      set_mask(0, 32'hF0F0_3C3C ^ 32'(p * 32'h0101_0101));
      set_mask(1, ~m_mask[0] | 32'(p));
      irq = lv;
      settle(4);
      chk($sformatf("R5 R1 pattern %0d", p), {2'b0, irq_out}, exp_out(lv));
    end

    irq = '0;
    settle(4);
    chk("R11 all inputs low", {2'b0, irq_out}, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule